// File: doc/BRIEF.md
# Performance Event Counter Bank

This block sits beside a processor pipeline and counts what happens there. It holds seven 48-bit counters. One counts every clock cycle. One counts the cycles in which the vector unit reports busy. Five are programmable, and each follows a single-cycle event picked by its own selector. The events are an in-stack taken branch, a not-taken branch, and the retirement of one opcode that software chooses.

Software reaches the bank through a simple register port. A write takes effect on the next clock, and a read returns data in the same cycle. Through this port, code at any privilege level can read a counter, preset it and configure it. An operating system gives each process its own counts this way. On a process switch it sets the global freeze bit, reads all the counters and their settings into the old process's save area, writes in the new process's values and then clears the freeze bit. While frozen, no counter moves, so the saved snapshot is consistent.

Top module: `pmc_bank`

## Requirements
- R1: The cycle counter (address 0) increases by one on every clock edge while the freeze bit is clear.
- R2: The vector counter (address 1) increases by one on every clock edge where `vec_busy` is high and the freeze bit is clear.
- R3: Each counter holds 48 bits. A read returns the count in bits 47:0 and zero in bits 63:48. Unmapped addresses (7, 13 to 15, 17 to 31) read as zero.
- R4: Programmable counter i (address 2+i, config at address 8+i) counts according to the 3-bit select in config bits 2:0. Code 0 is off. Code 1 counts `br_stack_taken`. Code 2 counts `br_not_taken`. Code 3 counts opcode matches. Codes 4 to 7 count nothing.
- R5: An opcode match is a cycle with `retire_valid` high and `retire_opc` equal to the 8-bit match value held in config bits 15:8.
- R6: A write to a counter address loads `reg_wdata[47:0]` at the next clock edge. The load wins over an increment on the same edge.
- R7: When a counter steps from all ones to zero, it sets a sticky overflow bit at control bit 8+k, where k is the counter address. Writing 1 to that bit clears it. A wrap on the same edge as the clear keeps the bit set.
- R8: The control register (address 16) bit 0 is the freeze bit. While it is set, no counter moves, but writes to counters still load.
- R9: Reset clears all counters, all config registers, the freeze bit and all overflow bits.
- R10: A config register reads back its select in bits 2:0 and its match value in bits 15:8, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_stack_taken | input | 1 | Strobe: a branch taken within the instruction stack |
| br_not_taken | input | 1 | Strobe: a branch not taken |
| retire_valid | input | 1 | Strobe: an instruction retired this cycle |
| retire_opc | input | 8 | Opcode of the retiring instruction |
| vec_busy | input | 1 | Vector unit busy this cycle |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` |

## Verification
Read data depends on the address alone, in the same cycle, so the bench samples it a fraction of a nanosecond after setting the address in the low clock phase. A write or an increment shows up one edge later. The bench drives every write in the low phase and reads back only after the next falling edge, so it counts exactly one rising edge per write. The bench measures counting windows with the freeze bit. Clearing the freeze bit costs one edge with no count, and setting it still allows one last count. A window of n edges is therefore built as the unfreeze write, n-1 further edges and the freeze write, which gives exactly n counts. The bench then reads the frozen values.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int CNT_W     = 48;
  localparam int REG_W     = 64;
  localparam int SEL_W     = 3;
  localparam int OPC_W     = 8;
  localparam int NUM_PROG  = 5;
  localparam int NUM_FIXED = 2;
  localparam int NUM_CNT   = NUM_FIXED + NUM_PROG;
  localparam int ADDR_W    = 5;
  localparam int CFG_BASE  = 8;
  localparam int CTRL_ADDR = 16;
  localparam int OVF_LSB   = 8;
  localparam int MATCH_LSB = 8;

  localparam logic [SEL_W-1:0] EV_OFF      = 3'd0;
  localparam logic [SEL_W-1:0] EV_BR_STACK = 3'd1;
  localparam logic [SEL_W-1:0] EV_BR_NT    = 3'd2;
  localparam logic [SEL_W-1:0] EV_OPC      = 3'd3;

  typedef struct packed {
    logic [OPC_W-1:0] match;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/pmc_counter.sv
`timescale 1ns/1ps
module pmc_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en   = ld | inc;
    wrap = inc & ~ld & (&cnt_q);
    if (ld)
      cnt_d = ld_val;
    else
      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pmc_event_sel.sv
`timescale 1ns/1ps
module pmc_event_sel
  import pmc_pkg::*;
(
  input  cfg_t             cfg,
  input  logic             br_stack_taken,
  input  logic             br_not_taken,
  input  logic             retire_valid,
  input  logic [OPC_W-1:0] retire_opc,
  output logic             hit
);
  always_comb begin
    unique case (cfg.sel)
      EV_BR_STACK: hit = br_stack_taken;
      EV_BR_NT:    hit = br_not_taken;
      EV_OPC:      hit = retire_valid & (retire_opc == cfg.match);
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmc_ctrl.sv
`timescale 1ns/1ps
module pmc_ctrl #(
  parameter int NCNT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            freeze_wr,
  input  logic [NCNT-1:0] clr_mask,
  input  logic [NCNT-1:0] wrap,
  output logic            freeze,
  output logic [NCNT-1:0] ovf
);
  logic            freeze_q, freeze_d;
  logic [NCNT-1:0] ovf_q, ovf_d;
  logic            ovf_en;

  always_comb begin
    freeze_d = freeze_wr;
    ovf_en   = ctrl_we | (|wrap);
    ovf_d    = (ovf_q & ~(ctrl_we ? clr_mask : '0)) | wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      freeze_q <= 1'b0;
    else if (ctrl_we)
      freeze_q <= freeze_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_q <= '0;
    else if (ovf_en)
      ovf_q <= ovf_d;
  end

  assign freeze = freeze_q;
  assign ovf    = ovf_q;
endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_stack_taken,
  input  logic              br_not_taken,
  input  logic              retire_valid,
  input  logic [OPC_W-1:0]  retire_opc,
  input  logic              vec_busy,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            cnt_ld;
  logic [NUM_CNT-1:0]            cnt_inc;
  logic [NUM_CNT-1:0]            cnt_wrap;
  logic [NUM_PROG-1:0]           ev_hit;
  logic [NUM_PROG-1:0]           cfg_we;
  cfg_t                          cfg_q [NUM_PROG];
  cfg_t                          cfg_d;
  logic                          ctrl_we;
  logic                          freeze_q;
  logic [NUM_CNT-1:0]            ovf_q;
  logic                          unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:CNT_W];

  // write decode
  always_comb begin
    ctrl_we = reg_we & (reg_addr == ADDR_W'(CTRL_ADDR));
    for (int k = 0; k < NUM_CNT; k++)
      cnt_ld[k] = reg_we & (reg_addr == ADDR_W'(k));
    for (int i = 0; i < NUM_PROG; i++)
      cfg_we[i] = reg_we & (reg_addr == ADDR_W'(CFG_BASE + i));
    cfg_d.sel   = reg_wdata[SEL_W-1:0];
    cfg_d.match = reg_wdata[MATCH_LSB +: OPC_W];
  end

  // configuration registers and event selection
  for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[i] <= '0;
      else if (cfg_we[i])
        cfg_q[i] <= cfg_d;
    end

    pmc_event_sel u_sel (
      .cfg            (cfg_q[i]),
      .br_stack_taken (br_stack_taken),
      .br_not_taken   (br_not_taken),
      .retire_valid   (retire_valid),
      .retire_opc     (retire_opc),
      .hit            (ev_hit[i])
    );
  end

  // increment sources
  always_comb begin
    cnt_inc[0] = ~freeze_q;
    cnt_inc[1] = ~freeze_q & vec_busy;
    for (int i = 0; i < NUM_PROG; i++)
      cnt_inc[NUM_FIXED + i] = ~freeze_q & ev_hit[i];
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    pmc_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cnt_ld[k]),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .inc    (cnt_inc[k]),
      .cnt    (cnt_all[k]),
      .wrap   (cnt_wrap[k])
    );
  end

  pmc_ctrl #(.NCNT(NUM_CNT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .freeze_wr (reg_wdata[0]),
    .clr_mask  (reg_wdata[OVF_LSB +: NUM_CNT]),
    .wrap      (cnt_wrap),
    .freeze    (freeze_q),
    .ovf       (ovf_q)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (reg_addr == ADDR_W'(k))
        reg_rdata[CNT_W-1:0] = cnt_all[k];
    for (int i = 0; i < NUM_PROG; i++)
      if (reg_addr == ADDR_W'(CFG_BASE + i)) begin
        reg_rdata[SEL_W-1:0]          = cfg_q[i].sel;
        reg_rdata[MATCH_LSB +: OPC_W] = cfg_q[i].match;
      end
    if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata[0]                  = freeze_q;
      reg_rdata[OVF_LSB +: NUM_CNT] = ovf_q;
    end
  end
endmodule

// File: rtl/pmc_bank_chk.sv
`timescale 1ns/1ps
module pmc_bank_chk
  import pmc_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [REG_W-1:0]              reg_wdata,
  input logic [REG_W-1:0]              reg_rdata,
  input logic                          freeze_q,
  input logic [NUM_CNT-1:0]            ovf_q,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all
);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:CNT_W] == '0);

  a_r1_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_q && !(reg_we && reg_addr == ADDR_W'(0)))
    |=> cnt_all[0] == $past(cnt_all[0]) + CNT_W'(1));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(NUM_FIXED))
    |=> cnt_all[NUM_FIXED] == $past(reg_wdata[CNT_W-1:0]));

  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !(reg_we && reg_addr < ADDR_W'(NUM_CNT)))
    |=> $stable(cnt_all));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q[0] && !(reg_we && reg_addr == ADDR_W'(CTRL_ADDR) && reg_wdata[OVF_LSB]))
    |=> ovf_q[0]);
endmodule

bind pmc_bank pmc_bank_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .freeze_q  (freeze_q),
  .ovf_q     (ovf_q),
  .cnt_all   (cnt_all)
);

// File: tb/pmc_bank_tb_top.sv
`timescale 1ns/1ps
module pmc_bank_tb_top;
  import pmc_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              br_stack_taken, br_not_taken, retire_valid, vec_busy;
  logic [OPC_W-1:0]  retire_opc;
  logic              reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [REG_W-1:0]  reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  localparam int N = 10;

  always #2 clk = ~clk;

  pmc_bank dut_i (
    .clk(clk), .rst_n(rst_n), .br_stack_taken(br_stack_taken),
    .br_not_taken(br_not_taken), .retire_valid(retire_valid),
    .retire_opc(retire_opc), .vec_busy(vec_busy), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic [2:0] sel;
    logic [7:0] match;
    logic       bstk;
    logic       bnt;
    logic       rv;
    logic [7:0] opc;
    logic       vb;
    logic       hit;
  } vec_t;

  // sel, match, bstk, bnt, rv, opc, vb, expected hit
  localparam vec_t VECS [10] = '{
    '{3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    '{3'd1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{3'd2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},
    '{3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{3'd3, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1},
    '{3'd3, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h5B, 1'b1, 1'b0},
    '{3'd3, 8'h5A, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0},
    '{3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},
    '{3'd5, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},
    '{3'd7, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive in the low phase; the next rising edge commits; return at the next falling edge
  task automatic wr(input int a, input logic [63:0] d);
    reg_we    = 1'b1;
    reg_addr  = ADDR_W'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    reg_addr = ADDR_W'(a);
    #0.2;
    d = reg_rdata;
  endtask

  // exactly n counting edges, ends frozen
  task automatic run_window(input int n);
    wr(CTRL_ADDR, 64'h1 ^ 64'h1);
    repeat (n - 1) @(negedge clk);
    wr(CTRL_ADDR, 64'h1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 1'b0;
    br_stack_taken = 1'b0; br_not_taken = 1'b0; retire_valid = 1'b0;
    retire_opc = '0; vec_busy = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (2) @(negedge clk);

    // R9: reset state of every register
    for (int a = 0; a < NUM_CNT; a++) begin rd(a, d); chk("R9 counter reset", d, 64'h0); end
    for (int a = 0; a < NUM_PROG; a++) begin rd(CFG_BASE + a, d); chk("R9 config reset", d, 64'h0); end
    rd(CTRL_ADDR, d); chk("R9 control reset", d, 64'h0);

    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(CTRL_ADDR, 64'h1);

    // table of event patterns: R1 R2 R4 R5
    for (int v = 0; v < 10; v++) begin
      wr(CFG_BASE, {48'h0, VECS[v].match, 5'h0, VECS[v].sel});
      wr(0, 64'h0); wr(1, 64'h0); wr(2, 64'h0);
      br_stack_taken = VECS[v].bstk; br_not_taken = VECS[v].bnt;
      retire_valid = VECS[v].rv; retire_opc = VECS[v].opc; vec_busy = VECS[v].vb;
      run_window(N);
      br_stack_taken = 1'b0; br_not_taken = 1'b0; retire_valid = 1'b0;
      retire_opc = '0; vec_busy = 1'b0;
      rd(0, d); chk("R1 cycle count over window", d, 64'(N));
      rd(1, d); chk("R2 vector busy count", d, VECS[v].vb ? 64'(N) : 64'h0);
      rd(2, d); chk("R4/R5 selected event count", d, VECS[v].hit ? 64'(N) : 64'h0);
    end

    // R3: upper bits read zero, unmapped addresses read zero
    wr(3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3, d);  chk("R3 upper bits zero", d, 64'h0000_FFFF_FFFF_FFFF);
    rd(7, d);  chk("R3 unmapped address 7", d, 64'h0);
    rd(31, d); chk("R3 unmapped address 31", d, 64'h0);

    // R10: config readback
    wr(CFG_BASE + 1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(CFG_BASE + 1, d); chk("R10 config readback", d, 64'h0000_0000_0000_FF07);

    // R7: wrap sets sticky overflow, write-1 clears
    wr(0, 64'h0000_FFFF_FFFF_FFFE);
    run_window(3);
    rd(0, d); chk("R7 counter wrapped to zero and stepped", d, 64'h1);
    rd(CTRL_ADDR, d); chk("R7 overflow bit 8 set", d, 64'h101);
    @(negedge clk);
    wr(CTRL_ADDR, 64'h101);
    rd(CTRL_ADDR, d); chk("R7 overflow cleared by write 1", d, 64'h1);

    // R6: load wins over increment while running
    @(negedge clk);
    wr(CTRL_ADDR, 64'h0);
    wr(0, 64'd100);
    rd(0, d); chk("R6 load wins over increment", d, 64'd100);
    @(negedge clk);
    rd(0, d); chk("R1 increments after load", d, 64'd101);
    @(negedge clk);
    wr(CTRL_ADDR, 64'h1);
    rd(0, d); chk("R8 last count before freeze", d, 64'd103);
    repeat (5) @(negedge clk);
    rd(0, d); chk("R8 frozen counter holds", d, 64'd103);

    // R8: writes load while frozen
    @(negedge clk);
    wr(2, 64'd77);
    repeat (3) @(negedge clk);
    rd(2, d); chk("R8 load while frozen holds", d, 64'd77);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule